// File: doc/BRIEF.md
# Ping-Pong Batch Sample Buffer

This block gathers converter samples into memory with no per-sample software action. Each cycle in which the upstream receive path flags a sample as available, the sample goes into the next free slot of the active bank. There are two equal banks, each holding one batch of `BATCH_N` samples. When the active bank fills, the block emits a single-cycle batch-complete event, swaps banks, and hands the freshly filled bank to a consumer through a registered read port. New samples meanwhile flow into the other bank.

The consumer has until the next batch completes to process its bank and release it with a done pulse. If a batch completes while the previous bank is still held, a sticky overrun flag is set, and the new batch is written anyway. The flag stays set until it is cleared explicitly. Several channels can be collected side by side into their own bank pairs, sharing one write position. Only channel 0 advances that position and produces the completion event, because all channels are assumed to be sampled together.

Top module: `pingpong_batch_buf`

## Requirements
- R1: After synchronous reset, `active_bank`, `batch_done`, `bank_held` and `overrun` are all 0, and the next sample accepted on channel 0 lands at address 0 of bank 0.
- R2: On each clock edge where `in_valid[c]` is high, the channel c sample on `in_data[c*DATA_W +: DATA_W]` is written at the current write position of the active bank. A cycle with `in_valid` low writes nothing.
- R3: `batch_done` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the `BATCH_N`-th channel 0 sample of a batch.
- R4: `active_bank` toggles in the same cycle that `batch_done` is high, and at no other time. The write position then restarts at 0.
- R5: One cycle after `rd_addr` is presented, `rd_data` returns the samples at that address of the bank that is not active. Channel c occupies bits `[c*DATA_W +: DATA_W]`.
- R6: Writes into the active bank never alter the contents read back from the inactive bank.
- R7: `bank_held` goes high with every `batch_done` and drops after a clock edge with `cons_release` high and no completion on that edge.
- R8: If a batch completes while `bank_held` is high and `cons_release` is low on that edge, `overrun` is set, and the new batch is still stored. A release on the same edge as a completion prevents the overrun.
- R9: `overrun` stays high until a clock edge with `ovr_clr` high. If a new overrun occurs on that same edge, the flag stays set.
- R10: Only `in_valid[0]` advances the write position. Channel 1 samples alone never cause `batch_done` or a bank change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_CH | Per-channel sample available strobe |
| in_data | input | NUM_CH*DATA_W | Packed channel samples, channel 0 in the low bits |
| rd_addr | input | $clog2(BATCH_N) | Consumer read address within the readable bank |
| rd_data | output | NUM_CH*DATA_W | Registered read data from the readable bank, all channels |
| cons_release | input | 1 | Consumer done pulse that releases the held bank |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| batch_done | output | 1 | One-cycle batch-complete event |
| active_bank | output | 1 | Index of the bank currently being written |
| bank_held | output | 1 | The readable bank has not yet been released |
| overrun | output | 1 | Sticky late-consumer flag |

## Verification
The bench builds the block with `BATCH_N` = 4, two channels and 16-bit samples. The short batch lets one run cover several bank swaps in both directions. It also fits a clean release, a late consumer, a flag clear part-way through a batch, and a release landing on the same edge as a completion. With two channels, the bench can show that channel 1 data follows channel 0 into the same slots and that channel 1 strobes alone never complete a batch.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef struct packed {
    logic active;
    logic done;
    logic held;
    logic overrun;
  } pp_ctrl_t;
endpackage

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_batch_ctrl.sv
module pp_batch_ctrl #(
  parameter int BATCH_N = 8,
  parameter int PTR_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             release_i,
  input  logic             ovr_clr,
  output logic [PTR_W-1:0] wptr,
  output pp_pkg::pp_ctrl_t st
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(BATCH_N - 1);

  logic complete;
  assign complete = push && (wptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      st.active  <= 1'b0;
      st.done    <= 1'b0;
      st.held    <= 1'b0;
      st.overrun <= 1'b0;
    end else begin
      st.done <= complete;
      if (complete) begin
        wptr      <= '0;
        st.active <= ~st.active;
      end else if (push) begin
        wptr <= wptr + 1'b1;
      end
      if (complete)       st.held <= 1'b1;
      else if (release_i) st.held <= 1'b0;
      if (complete && st.held && !release_i) st.overrun <= 1'b1;
      else if (ovr_clr)                      st.overrun <= 1'b0;
    end
  end

  initial begin
    assert (BATCH_N >= 2) else $error("BATCH_N must be at least 2");
  end

  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wptr <= LAST);

  // R3
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    st.done |=> !st.done);

  // R4
  bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
    st.done |-> (st.active != $past(st.active)));

  // R4
  bank_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !st.done |-> $stable(st.active));

  // R7
  held_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    st.done |-> st.held);

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st.overrun) |-> (st.done && $past(st.held)));

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st.overrun && !ovr_clr) |=> st.overrun);
endmodule

// File: rtl/pingpong_batch_buf.sv
module pingpong_batch_buf #(
  parameter int DATA_W  = 16,
  parameter int BATCH_N = 8,
  parameter int NUM_CH  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH-1:0]             in_valid,
  input  logic [NUM_CH*DATA_W-1:0]      in_data,
  input  logic [$clog2(BATCH_N)-1:0]    rd_addr,
  output logic [NUM_CH*DATA_W-1:0]      rd_data,
  input  logic                          cons_release,
  input  logic                          ovr_clr,
  output logic                          batch_done,
  output logic                          active_bank,
  output logic                          bank_held,
  output logic                          overrun
);
  localparam int PTR_W  = $clog2(BATCH_N);
  localparam int ADDR_W = PTR_W + 1;

  logic [PTR_W-1:0]  wptr;
  pp_pkg::pp_ctrl_t  st;

  pp_batch_ctrl #(.BATCH_N(BATCH_N), .PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push      (in_valid[0]),
    .release_i (cons_release),
    .ovr_clr   (ovr_clr),
    .wptr      (wptr),
    .st        (st)
  );

  logic [ADDR_W-1:0] waddr, raddr;
  assign waddr = {st.active, wptr};
  assign raddr = {~st.active, rd_addr};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pp_bank_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (in_valid[c]),
      .waddr (waddr),
      .wdata (in_data[c*DATA_W +: DATA_W]),
      .raddr (raddr),
      .rdata (rd_data[c*DATA_W +: DATA_W])
    );
  end

  assign batch_done  = st.done;
  assign active_bank = st.active;
  assign bank_held   = st.held;
  assign overrun     = st.overrun;

  // R10
  primary_only_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid[0] |=> !batch_done);

  // R7
  release_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cons_release && !batch_done && bank_held && !(in_valid[0] && wptr == PTR_W'(BATCH_N-1)))
      |=> !bank_held);
endmodule

// File: tb/tb_pingpong_batch_buf.sv
module tb_pingpong_batch_buf;
  localparam int DW = 16;
  localparam int BN = 4;
  localparam int NC = 2;
  localparam int PW = $clog2(BN);

  logic clk = 0;
  logic rst;
  logic [NC-1:0]    in_valid;
  logic [NC*DW-1:0] in_data;
  logic [PW-1:0]    rd_addr;
  logic [NC*DW-1:0] rd_data;
  logic cons_release, ovr_clr;
  logic batch_done, active_bank, bank_held, overrun;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pingpong_batch_buf #(.DATA_W(DW), .BATCH_N(BN), .NUM_CH(NC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cons_release(cons_release),
    .ovr_clr(ovr_clr), .batch_done(batch_done), .active_bank(active_bank),
    .bank_held(bank_held), .overrun(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sample per channel; optional release on the same edge
  task automatic push(logic [DW-1:0] d0, logic [DW-1:0] d1, logic rel);
    in_valid = 2'b11; in_data = {d1, d0}; cons_release = rel;
    @(posedge clk); @(negedge clk);
    in_valid = '0; cons_release = 0;
  endtask

  task automatic fill(logic [DW-1:0] b0, logic [DW-1:0] b1, logic rel_last);
    for (int i = 0; i < BN; i++) begin
      push(b0 + DW'(i), b1 + DW'(i), rel_last && (i == BN-1));
      if (i < BN-1) chk("R3 no early done", batch_done, 0);
    end
    chk("R3 done after last sample", batch_done, 1);
  endtask

  task automatic read_bank(string req, logic [DW-1:0] b0, logic [DW-1:0] b1);
    for (int i = 0; i < BN; i++) begin
      rd_addr = PW'(i);
      @(posedge clk); @(negedge clk);
      chk({req, " ch0"}, rd_data[DW-1:0],  b0 + DW'(i));
      chk({req, " ch1"}, rd_data[2*DW-1:DW], b1 + DW'(i));
    end
  endtask

  task automatic pulse_release();
    cons_release = 1; @(posedge clk); @(negedge clk); cons_release = 0;
  endtask

  task automatic t_reset();
    chk("R1 active", active_bank, 0);
    chk("R1 done", batch_done, 0);
    chk("R1 held", bank_held, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_first_batch();
    fill(16'h0100, 16'h0200, 0);
    chk("R4 active flips", active_bank, 1);
    chk("R7 held on done", bank_held, 1);
    @(posedge clk); @(negedge clk);
    chk("R3 single cycle", batch_done, 0);
    read_bank("R1 R5 bank0", 16'h0100, 16'h0200);
  endtask

  task automatic t_ignore();
    in_data = {16'hDEAD, 16'hBEEF};
    in_valid = 2'b00;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    in_valid = 2'b10;
    repeat (5) begin
      @(posedge clk); @(negedge clk);
      chk("R10 ch1 alone no done", batch_done, 0);
    end
    in_valid = '0;
    chk("R10 no bank change", active_bank, 1);
    read_bank("R2 idle cycles write nothing", 16'h0100, 16'h0200);
  endtask

  task automatic t_release_and_second();
    pulse_release();
    chk("R7 release drops held", bank_held, 0);
    push(16'h0300, 16'h0400, 0);
    push(16'h0301, 16'h0401, 0);
    read_bank("R6 inactive undisturbed", 16'h0100, 16'h0200);
    push(16'h0302, 16'h0402, 0);
    push(16'h0303, 16'h0403, 0);
    chk("R3 done second batch", batch_done, 1);
    chk("R4 active back to 0", active_bank, 0);
    chk("R8 no overrun after release", overrun, 0);
    read_bank("R5 bank1", 16'h0300, 16'h0400);
  endtask

  task automatic t_overrun();
    fill(16'h0500, 16'h0600, 0);
    chk("R8 overrun set", overrun, 1);
    read_bank("R8 data still written", 16'h0500, 16'h0600);
    push(16'h0700, 16'h0800, 0);
    push(16'h0701, 16'h0801, 0);
    chk("R9 overrun sticky", overrun, 1);
    ovr_clr = 1; @(posedge clk); @(negedge clk); ovr_clr = 0;
    chk("R9 cleared", overrun, 0);
    push(16'h0702, 16'h0802, 0);
    in_valid = 2'b11; in_data = {16'h0803, 16'h0703}; ovr_clr = 1;
    @(posedge clk); @(negedge clk);
    in_valid = '0; ovr_clr = 0;
    chk("R3 done with clear", batch_done, 1);
    chk("R9 set wins over clear", overrun, 1);
    read_bank("R5 bank1 refill", 16'h0700, 16'h0800);
  endtask

  task automatic t_same_edge_release();
    ovr_clr = 1; @(posedge clk); @(negedge clk); ovr_clr = 0;
    chk("R9 cleared again", overrun, 0);
    fill(16'h0900, 16'h0A00, 1);
    chk("R8 same-edge release avoids overrun", overrun, 0);
    chk("R7 held after completion", bank_held, 1);
    read_bank("R5 bank0 final", 16'h0900, 16'h0A00);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    rst = 1; in_valid = '0; in_data = '0; rd_addr = '0;
    cons_release = 0; ovr_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_first_batch();
    t_ignore();
    t_release_and_second();
    t_overrun();
    t_same_edge_release();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule